// File: doc/BRIEF.md
# Dual Event Counter with Overflow Interrupts

This block watches a set of per-cycle event strobes from a processor pipeline and counts two of them at once, one per channel. Each channel has its own event selector and accumulates the chosen event. Once a chosen power-of-two number of events has been counted, the channel latches an interrupt request. The counter then wraps and keeps counting.

A small write-only register port configures the block. The configuration word holds both selectors, one period bit per channel and one disable bit per channel. A second address clears the interrupt requests and the configuration error flag, writing one to each bit to be cleared. Issue-related events are weighted: a cycle in which only one instruction issues adds half a unit. Each counter therefore keeps one extra fractional bit.

Top module: `dual_evt_mon`

## Requirements
- R1: After reset both interrupt requests and the error flag are low, and the configuration word is all zero: both channels are enabled on the long period, channel 0 selects the issue-weighted event and channel 1 selects data-cache misses.
- R2: Configuration word bits [3:0] select the channel 0 event. The codes are 0 issue-weighted, 1 pipe dry, 2 load, 3 pipe frozen, 4 branch, 5 every cycle, 6 privileged-mode cycle, 7 non-issue-weighted and 8 external input 0. Codes 9 to 15 count nothing.
- R3: Configuration word bits [6:4] select the channel 1 event. The codes are 0 data-cache miss, 1 instruction-cache miss, 2 dual issue (issue count of 2 or more), 3 branch mispredict, 4 FP operate, 5 integer operate, 6 store and 7 external input 1.
- R4: Channel 0 raises its interrupt when its count reaches 2^12 events if configuration bit 7 is set, and 2^16 events if it is clear.
- R5: Channel 1 raises its interrupt when its count reaches 2^8 events if configuration bit 8 is set, and 2^12 events if it is clear.
- R6: The issue-weighted event adds one unit when the issue count is 2 or more, half a unit when it is 1, and nothing when it is 0. The non-issue-weighted event adds one unit when the count is 0, half a unit when it is 1, and nothing when it is 2 or more. The interrupt fires only when the integer part reaches the period.
- R7: The pipe-dry and pipe-frozen events count every cycle in which the strobe is high, so a strobe held high for N cycles adds N.
- R8: Configuration bits [10:9] are per-channel disables: bit 9 disables channel 0 and bit 10 disables channel 1. A disabled channel holds its count and raises no interrupt, and counting resumes from the held value when it is enabled again.
- R9: A configuration write with both disable bits set leaves the whole configuration unchanged, including selectors and counts, and sets a sticky error flag. Writing 1 to bit 2 of the clear address lowers the flag.
- R10: An interrupt request stays high until 1 is written to its bit at the clear address (bit 0 for channel 0, bit 1 for channel 1). The counter wraps at the period and keeps counting events meanwhile.
- R11: An accepted configuration write that changes a channel's selector or period bit clears that channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the configuration word, 1 selects the clear register |
| wr_data_i | input | 11 | Write data |
| issue_cnt_i | input | ISSUE_W (2) | Number of instructions issued this cycle |
| pipe_dry_i | input | 1 | No valid instruction data to issue this cycle |
| load_i | input | 1 | Load instruction |
| pipe_frozen_i | input | 1 | Issue blocked by a resource conflict this cycle |
| branch_i | input | 1 | Branch instruction |
| priv_mode_i | input | 1 | Cycle spent in privileged mode |
| ext0_i | input | 1 | External event input 0 |
| dcache_miss_i | input | 1 | Data-cache miss |
| icache_miss_i | input | 1 | Instruction-cache miss |
| branch_miss_i | input | 1 | Mispredicted branch |
| fp_op_i | input | 1 | Floating-point operate instruction |
| int_op_i | input | 1 | Integer operate instruction |
| store_i | input | 1 | Store instruction |
| ext1_i | input | 1 | External event input 1 |
| irq_o | output | 2 | Sticky interrupt request per channel |
| cfg_err_o | output | 1 | Sticky flag for a rejected configuration write |

## Verification
A corrupted count shows up only when an interrupt fires. It appears as an interrupt that is early or late by the size of the error, so the bench checks one event before the threshold and exactly at the threshold. An error in the fractional bit moves the interrupt by exactly one half-weight cycle, and the issue tests probe that cycle directly. A wrong selector or enable appears within one period as a missing or spurious interrupt. A configuration change that fails to clear the count appears as an interrupt that arrives early.

// File: rtl/dual_evt_mon_pkg.sv
package dual_evt_mon_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH   = 2;
  localparam int CFG_W = 11;

  typedef struct packed {
    logic [1:0] dis;
    logic       fast1;
    logic       fast0;
    logic [2:0] sel1;
    logic [3:0] sel0;
  } cfg_t;

  typedef enum logic [3:0] {
    E0_ISSUE   = 4'd0,
    E0_DRY     = 4'd1,
    E0_LOAD    = 4'd2,
    E0_FROZEN  = 4'd3,
    E0_BRANCH  = 4'd4,
    E0_CYCLE   = 4'd5,
    E0_PRIV    = 4'd6,
    E0_NOISSUE = 4'd7,
    E0_EXT     = 4'd8
  } ev0_e;

  typedef enum logic [2:0] {
    E1_DMISS  = 3'd0,
    E1_IMISS  = 3'd1,
    E1_DUAL   = 3'd2,
    E1_BRMISS = 3'd3,
    E1_FPOP   = 3'd4,
    E1_INTOP  = 3'd5,
    E1_STORE  = 3'd6,
    E1_EXT    = 3'd7
  } ev1_e;

  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CLR = 1'b1;
  localparam int   CLR_ERR_BIT = 2;

  // weights in half units
  localparam logic [1:0] W_NONE = 2'd0;
  localparam logic [1:0] W_HALF = 2'd1;
  localparam logic [1:0] W_FULL = 2'd2;
endpackage

// File: rtl/dual_evt_mon_wgt.sv
module dual_evt_mon_wgt
  import dual_evt_mon_pkg::*;
#(
  parameter int ISSUE_W = 2
) (
  input  logic [3:0]         sel0_i,
  input  logic [2:0]         sel1_i,
  input  logic [ISSUE_W-1:0] issue_cnt_i,
  input  logic               pipe_dry_i,
  input  logic               load_i,
  input  logic               pipe_frozen_i,
  input  logic               branch_i,
  input  logic               priv_mode_i,
  input  logic               ext0_i,
  input  logic               dcache_miss_i,
  input  logic               icache_miss_i,
  input  logic               branch_miss_i,
  input  logic               fp_op_i,
  input  logic               int_op_i,
  input  logic               store_i,
  input  logic               ext1_i,
  output logic [1:0]         w0_o,
  output logic [1:0]         w1_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic iss_none, iss_one, iss_multi;

  assign iss_none  = (issue_cnt_i == '0);
  assign iss_one   = (issue_cnt_i == ISSUE_W'(1));
  assign iss_multi = !iss_none && !iss_one;

  function automatic logic [1:0] full(input logic ev);
    return ev ? W_FULL : W_NONE;
  endfunction

  always_comb begin
    unique case (sel0_i)
      E0_ISSUE:   w0_o = iss_multi ? W_FULL : (iss_one ? W_HALF : W_NONE);
      E0_DRY:     w0_o = full(pipe_dry_i);
      E0_LOAD:    w0_o = full(load_i);
      E0_FROZEN:  w0_o = full(pipe_frozen_i);
      E0_BRANCH:  w0_o = full(branch_i);
      E0_CYCLE:   w0_o = W_FULL;
      E0_PRIV:    w0_o = full(priv_mode_i);
      E0_NOISSUE: w0_o = iss_none ? W_FULL : (iss_one ? W_HALF : W_NONE);
      E0_EXT:     w0_o = full(ext0_i);
      default:    w0_o = W_NONE;
    endcase
  end

  always_comb begin
    unique case (sel1_i)
      E1_DMISS:  w1_o = full(dcache_miss_i);
      E1_IMISS:  w1_o = full(icache_miss_i);
      E1_DUAL:   w1_o = full(iss_multi);
      E1_BRMISS: w1_o = full(branch_miss_i);
      E1_FPOP:   w1_o = full(fp_op_i);
      E1_INTOP:  w1_o = full(int_op_i);
      E1_STORE:  w1_o = full(store_i);
      default:   w1_o = full(ext1_i);
    endcase
  end
endmodule

// File: rtl/dual_evt_mon_regs.sv
module dual_evt_mon_regs
  import dual_evt_mon_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output cfg_t             cfg_o,
  output logic [NCH-1:0]   cnt_clr_o,
  output logic [NCH-1:0]   irq_clr_o,
  output logic             err_o
);
  timeunit 1ns;
  timeprecision 1ps;

  cfg_t cfg_q, cfg_new;
  logic cfg_we, clr_we, bad, take, err_q;

  assign cfg_new = cfg_t'(wr_data_i);
  assign cfg_we  = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign clr_we  = wr_en_i && (wr_addr_i == ADDR_CLR);
  assign bad     = (cfg_new.dis == 2'b11);
  assign take    = cfg_we && !bad;

  assign cnt_clr_o[0] = take && ((cfg_new.sel0 != cfg_q.sel0) || (cfg_new.fast0 != cfg_q.fast0));
  assign cnt_clr_o[1] = take && ((cfg_new.sel1 != cfg_q.sel1) || (cfg_new.fast1 != cfg_q.fast1));
  assign irq_clr_o    = clr_we ? wr_data_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (take) cfg_q <= cfg_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               err_q <= 1'b0;
    else if (cfg_we && bad)                    err_q <= 1'b1;
    else if (clr_we && wr_data_i[CLR_ERR_BIT]) err_q <= 1'b0;
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  AST_BAD_WR_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we && bad) |=> $stable(cfg_q)); // R9
  AST_BAD_WR_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we && bad) |=> err_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(clr_we && wr_data_i[CLR_ERR_BIT])) |=> err_q); // R9
  AST_NEVER_BOTH_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.dis != 2'b11); // R9
endmodule

// File: rtl/dual_evt_mon_chan.sv
module dual_evt_mon_chan #(
  parameter int EXP_FAST = 8,
  parameter int EXP_SLOW = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fast_i,
  input  logic [1:0] wgt_i,
  input  logic       cnt_clr_i,
  input  logic       irq_clr_i,
  output logic       irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // one fractional bit plus headroom for the wrap compare
  localparam int CW = EXP_SLOW + 2;
  localparam logic [CW-1:0] ONE      = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] PER_FAST = ONE << (EXP_FAST + 1);
  localparam logic [CW-1:0] PER_SLOW = ONE << (EXP_SLOW + 1);

  logic [CW-1:0] cnt_q, sum, period;
  logic          hit, irq_q;

  always_comb begin
    period = fast_i ? PER_FAST : PER_SLOW;
    sum    = cnt_q + {{(CW-2){1'b0}}, wgt_i};
    hit    = en_i && !cnt_clr_i && (sum >= period);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cnt_clr_i) cnt_q <= '0;
    else if (en_i)      cnt_q <= hit ? (sum - period) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (hit)       irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period); // R4
  AST_WGT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wgt_i <= 2'd2); // R6
  AST_DIS_HOLDS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_clr_i) |=> $stable(cnt_q)); // R8
  AST_DIS_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(irq_q)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q); // R10
  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/dual_evt_mon.sv
module dual_evt_mon
  import dual_evt_mon_pkg::*;
#(
  parameter int ISSUE_W     = 2,
  parameter int C0_EXP_FAST = 12,
  parameter int C0_EXP_SLOW = 16,
  parameter int C1_EXP_FAST = 8,
  parameter int C1_EXP_SLOW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [10:0]        wr_data_i,
  input  logic [ISSUE_W-1:0] issue_cnt_i,
  input  logic               pipe_dry_i,
  input  logic               load_i,
  input  logic               pipe_frozen_i,
  input  logic               branch_i,
  input  logic               priv_mode_i,
  input  logic               ext0_i,
  input  logic               dcache_miss_i,
  input  logic               icache_miss_i,
  input  logic               branch_miss_i,
  input  logic               fp_op_i,
  input  logic               int_op_i,
  input  logic               store_i,
  input  logic               ext1_i,
  output logic [1:0]         irq_o,
  output logic               cfg_err_o
);
  timeunit 1ns;
  timeprecision 1ps;

  cfg_t           cfg;
  logic [NCH-1:0] cnt_clr, irq_clr, en, fast;
  logic [1:0]     wgt [NCH];

  dual_evt_mon_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .cnt_clr_o (cnt_clr),
    .irq_clr_o (irq_clr),
    .err_o     (cfg_err_o)
  );

  dual_evt_mon_wgt #(.ISSUE_W(ISSUE_W)) u_wgt (
    .sel0_i        (cfg.sel0),
    .sel1_i        (cfg.sel1),
    .issue_cnt_i   (issue_cnt_i),
    .pipe_dry_i    (pipe_dry_i),
    .load_i        (load_i),
    .pipe_frozen_i (pipe_frozen_i),
    .branch_i      (branch_i),
    .priv_mode_i   (priv_mode_i),
    .ext0_i        (ext0_i),
    .dcache_miss_i (dcache_miss_i),
    .icache_miss_i (icache_miss_i),
    .branch_miss_i (branch_miss_i),
    .fp_op_i       (fp_op_i),
    .int_op_i      (int_op_i),
    .store_i       (store_i),
    .ext1_i        (ext1_i),
    .w0_o          (wgt[0]),
    .w1_o          (wgt[1])
  );

  assign en   = ~cfg.dis;
  assign fast = {cfg.fast1, cfg.fast0};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int EF = (g == 0) ? C0_EXP_FAST : C1_EXP_FAST;
    localparam int ES = (g == 0) ? C0_EXP_SLOW : C1_EXP_SLOW;

    dual_evt_mon_chan #(.EXP_FAST(EF), .EXP_SLOW(ES)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[g]),
      .fast_i    (fast[g]),
      .wgt_i     (wgt[g]),
      .cnt_clr_i (cnt_clr[g]),
      .irq_clr_i (irq_clr[g]),
      .irq_o     (irq_o[g])
    );
  end
endmodule

// File: tb/dual_evt_mon_bench.sv
module dual_evt_mon_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [10:0] wr_data = '0;
  logic [1:0] issue_cnt = '0;
  logic pipe_dry = 0, load = 0, frozen = 0, branch = 0, priv = 0, ext0 = 0;
  logic dmiss = 0, imiss = 0, brmiss = 0, fpop = 0, intop = 0, store = 0, ext1 = 0;
  logic [1:0] irq;
  logic cfg_err;
  logic [1:0] base_issue = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_evt_mon u_dual_evt_mon (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .issue_cnt_i(issue_cnt), .pipe_dry_i(pipe_dry), .load_i(load), .pipe_frozen_i(frozen),
    .branch_i(branch), .priv_mode_i(priv), .ext0_i(ext0), .dcache_miss_i(dmiss),
    .icache_miss_i(imiss), .branch_miss_i(brmiss), .fp_op_i(fpop), .int_op_i(intop),
    .store_i(store), .ext1_i(ext1), .irq_o(irq), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [10:0] cfgw(input logic [3:0] s0, input logic [2:0] s1,
                                       input logic f0, input logic f1, input logic [1:0] dis);
    return {dis, f1, f0, s1, s0};
  endfunction

  task automatic wr(input logic a, input logic [10:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_off();
    pipe_dry = 0; load = 0; frozen = 0; branch = 0; priv = 0; ext0 = 0;
    dmiss = 0; imiss = 0; brmiss = 0; fpop = 0; intop = 0; store = 0; ext1 = 0;
  endtask

  task automatic fresh(input logic [3:0] s0, input logic [2:0] s1,
                       input logic f0, input logic f1, input logic [1:0] dis);
    all_off();
    base_issue = (s0 == 4'd7) ? 2'd2 : 2'd0;
    issue_cnt = base_issue;
    wr(1'b1, 11'b011);
    wr(1'b0, cfgw(s0, s1, !f0, !f1, dis));
    wr(1'b0, cfgw(s0, s1, f0, f1, dis));
  endtask

  task automatic set_ev0(input int code, input logic on);
    case (code)
      0: issue_cnt = on ? 2'd2 : base_issue;
      1: pipe_dry = on;
      2: load = on;
      3: frozen = on;
      4: branch = on;
      6: priv = on;
      7: issue_cnt = on ? 2'd0 : base_issue;
      8: ext0 = on;
      default: ;
    endcase
  endtask

  task automatic set_ev1(input int code, input logic on);
    case (code)
      0: dmiss = on;
      1: imiss = on;
      2: issue_cnt = on ? 2'd2 : base_issue;
      3: brmiss = on;
      4: fpop = on;
      5: intop = on;
      6: store = on;
      default: ext1 = on;
    endcase
  endtask

  task automatic drive0(input int code, input int n);
    set_ev0(code, 1'b1); run(n); set_ev0(code, 1'b0);
  endtask

  task automatic drive1(input int code, input int n);
    set_ev1(code, 1'b1); run(n); set_ev1(code, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 irq0 after reset", irq[0], 1'b0);
    chk("R1 irq1 after reset", irq[1], 1'b0);
    chk("R1 err after reset", cfg_err, 1'b0);
    run(20);
    chk("R1 default cfg idle irq", |irq, 1'b0);
  endtask

  task automatic t_ch0_codes();
    for (int c = 0; c < 9; c++) begin
      fresh(4'(c), 3'd6, 1'b1, 1'b1, 2'b00);
      drive0(c, 4095);
      chk($sformatf("R2 R4 R7 ch0 code %0d below 4096", c), irq[0], 1'b0);
      drive0(c, 1);
      chk($sformatf("R2 R4 R7 ch0 code %0d at 4096", c), irq[0], 1'b1);
    end
  endtask

  task automatic t_ch0_unused();
    fresh(4'd9, 3'd6, 1'b1, 1'b1, 2'b00);
    pipe_dry = 1; load = 1; frozen = 1; branch = 1; priv = 1; ext0 = 1; issue_cnt = 2'd1;
    run(5000);
    all_off(); issue_cnt = 2'd0;
    chk("R2 ch0 unused code counts nothing", irq[0], 1'b0);
  endtask

  task automatic t_ch0_slow();
    fresh(4'd5, 3'd6, 1'b0, 1'b1, 2'b00);
    run(65535);
    chk("R4 ch0 slow below 65536", irq[0], 1'b0);
    run(1);
    chk("R4 ch0 slow at 65536", irq[0], 1'b1);
  endtask

  task automatic t_ch1_codes();
    for (int c = 0; c < 8; c++) begin
      fresh(4'd9, 3'(c), 1'b1, 1'b1, 2'b00);
      drive1(c, 255);
      chk($sformatf("R3 R5 ch1 code %0d below 256", c), irq[1], 1'b0);
      drive1(c, 1);
      chk($sformatf("R3 R5 ch1 code %0d at 256", c), irq[1], 1'b1);
    end
    fresh(4'd9, 3'd6, 1'b1, 1'b0, 2'b00);
    drive1(6, 4095);
    chk("R5 ch1 slow below 4096", irq[1], 1'b0);
    drive1(6, 1);
    chk("R5 ch1 slow at 4096", irq[1], 1'b1);
  endtask

  task automatic t_half();
    fresh(4'd0, 3'd6, 1'b1, 1'b1, 2'b00);
    issue_cnt = 2'd2; run(2048);
    issue_cnt = 2'd1; run(4094);
    chk("R6 issue 4095", irq[0], 1'b0);
    run(1);
    chk("R6 issue 4095.5", irq[0], 1'b0);
    run(1);
    chk("R6 issue 4096", irq[0], 1'b1);
    issue_cnt = 2'd0;
    fresh(4'd7, 3'd6, 1'b1, 1'b1, 2'b00);
    issue_cnt = 2'd0; run(4095);
    issue_cnt = 2'd2; run(300);
    chk("R6 nonissue 4095 plus dual cycles", irq[0], 1'b0);
    issue_cnt = 2'd1; run(1);
    chk("R6 nonissue 4095.5", irq[0], 1'b0);
    run(1);
    chk("R6 nonissue 4096", irq[0], 1'b1);
    issue_cnt = 2'd2;
  endtask

  task automatic t_sticky_wrap();
    fresh(4'd9, 3'd6, 1'b1, 1'b1, 2'b00);
    drive1(6, 256);
    chk("R10 irq1 set", irq[1], 1'b1);
    drive1(6, 100);
    chk("R10 irq1 sticky", irq[1], 1'b1);
    wr(1'b1, 11'b010);
    chk("R10 irq1 w1c", irq[1], 1'b0);
    drive1(6, 155);
    chk("R10 wrap 255", irq[1], 1'b0);
    drive1(6, 1);
    chk("R10 wrap 256", irq[1], 1'b1);
  endtask

  task automatic t_disable();
    fresh(4'd9, 3'd6, 1'b1, 1'b1, 2'b00);
    drive1(6, 200);
    wr(1'b0, cfgw(4'd9, 3'd6, 1'b1, 1'b1, 2'b10));
    drive1(6, 300);
    chk("R8 ch1 disabled no irq", irq[1], 1'b0);
    wr(1'b0, cfgw(4'd9, 3'd6, 1'b1, 1'b1, 2'b00));
    drive1(6, 55);
    chk("R8 ch1 held count 255", irq[1], 1'b0);
    drive1(6, 1);
    chk("R8 ch1 held count 256", irq[1], 1'b1);
    fresh(4'd5, 3'd6, 1'b1, 1'b1, 2'b01);
    run(5000);
    chk("R8 ch0 disabled no irq", irq[0], 1'b0);
  endtask

  task automatic t_bad_dis();
    fresh(4'd9, 3'd6, 1'b1, 1'b1, 2'b00);
    drive1(6, 100);
    wr(1'b0, cfgw(4'd9, 3'd5, 1'b0, 1'b0, 2'b11));
    chk("R9 err set", cfg_err, 1'b1);
    drive1(6, 155);
    chk("R9 cfg kept 255", irq[1], 1'b0);
    drive1(6, 1);
    chk("R9 cfg kept 256", irq[1], 1'b1);
    chk("R9 err sticky", cfg_err, 1'b1);
    wr(1'b1, 11'b100);
    chk("R9 err cleared", cfg_err, 1'b0);
  endtask

  task automatic t_clear_on_change();
    fresh(4'd9, 3'd6, 1'b1, 1'b1, 2'b00);
    drive1(6, 200);
    wr(1'b0, cfgw(4'd9, 3'd4, 1'b1, 1'b1, 2'b00));
    drive1(4, 255);
    chk("R11 sel change cleared 255", irq[1], 1'b0);
    drive1(4, 1);
    chk("R11 sel change cleared 256", irq[1], 1'b1);
    fresh(4'd9, 3'd6, 1'b1, 1'b1, 2'b00);
    drive1(6, 200);
    wr(1'b0, cfgw(4'd9, 3'd6, 1'b1, 1'b0, 2'b00));
    wr(1'b0, cfgw(4'd9, 3'd6, 1'b1, 1'b1, 2'b00));
    drive1(6, 255);
    chk("R11 freq change cleared 255", irq[1], 1'b0);
    drive1(6, 1);
    chk("R11 freq change cleared 256", irq[1], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ch1_codes();
    t_sticky_wrap();
    t_disable();
    t_bad_dis();
    t_clear_on_change();
    t_half();
    t_ch0_unused();
    t_ch0_codes();
    t_ch0_slow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule